// File: doc/BRIEF.md
# Byte-Stream Hash Block Assembler

This block sits in front of a 512-bit-per-block hash compression engine. A host presents an already padded message one byte at a time. The assembler packs the bytes into a block register, most significant byte first. When a block is full it launches the engine, then waits for the engine's completion pulse. It keeps the engine's result as the chaining state for the next block. The host throttles itself on `inReady`, which drops while a block is being compressed.

A message begins with a byte flagged by `msgStart` and ends with a byte flagged by `dataLast`. The message can span any number of blocks. When the block that carries the last byte has been compressed, the assembler raises `done` for one cycle. The result stays on `digest` until a later message overwrites it.

A message whose last byte does not fill its block exactly is treated as malformed. The partial block is discarded and no compression takes place. The compression engine itself lives outside this block. The top exposes the launch strobe, the first-block flag, the block, the chaining value, the engine's completion pulse and the engine's result as plain ports.

Top module: `byte_block_assembler`

## Requirements
- R1: After reset, `inReady` is 1, `done` is 0, `engStart` is 0, `digest` is all zeros and `engBlock` is all zeros.
- R2: Within a block, the first accepted byte lands in `engBlock[511:504]`. Each following byte lands in the next lower byte position, so byte k of the block occupies bits `[511-8k -: 8]`.
- R3: While idle, a byte presented with `dataValid`=1 and `msgStart`=0 is ignored and leaves `engBlock` unchanged.
- R4: The cycle after the 64th byte of a block is accepted, `engStart` is 1 for exactly one cycle. `engFirst` is 1 when that block is the first of its message.
- R5: `inReady` is 0 from the launch of a block until the cycle after the engine's completion pulse `engDone`. It returns to 1 after that completion if the message continues.
- R6: For every block after the first of a message, `engFirst` is 0 and `engChain` equals the `engHash` value returned for the previous block.
- R7: When the block carrying `dataLast` completes, `done` is 1 for exactly one cycle, the cycle after `engDone`, and `digest` equals the `engHash` presented with that `engDone`.
- R8: `digest` changes only when a block completes. It stays stable through a malformed message and through the loading of a following message.
- R9: If `dataLast` comes with a byte that is not the 64th of its block, the block is discarded. `engBlock` becomes all zeros, no launch occurs, and `inReady` is 1 in the next cycle so a new message can begin.
- R10: A byte presented while `inReady` is 0 is ignored, even when `msgStart` is 1, and the block under compression stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 8 | Message byte |
| dataValid | input | 1 | dataIn holds a byte this cycle |
| msgStart | input | 1 | Byte is the first of a new message |
| dataLast | input | 1 | Byte is the final padded byte of the message |
| inReady | output | 1 | A byte can be accepted this cycle |
| done | output | 1 | One-cycle pulse: digest holds the finished result |
| digest | output | 256 | Final hash result of the last message |
| engStart | output | 1 | One-cycle launch strobe to the engine |
| engFirst | output | 1 | Engine should start from its initial value, not engChain |
| engBlock | output | 512 | Assembled block for the engine |
| engChain | output | 256 | Chaining value from the previous block |
| engDone | input | 1 | One-cycle completion pulse from the engine |
| engHash | input | 256 | Engine result, valid with engDone |

## Verification
The bench builds the block with its default parameters: 8-bit bytes, 64-byte blocks and a 256-bit digest. The real 512-bit block layout and the 64th-byte launch boundary are therefore exercised exactly. The bench stands in for the engine with a completion latency chosen per vector, so messages of one, two and three blocks run with different stall lengths and with gaps between input bytes. The chaining value, the first-block flag and the final digest are all reached through these runs. Directed cases cover a stray byte without a start flag, bytes pushed during compression, and a message cut short by an early last flag.

// File: rtl/bba_pkg.sv
package bba_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_HASH = 2'd2,
    ST_DONE = 2'd3
  } state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadByte;     // write dataIn into the lane selected by laneIdx
    logic clearBlock;   // discard the partial block
    logic captureHash;  // latch the engine result as chaining state
  } strobe_t;

endpackage

// File: rtl/bba_ctrl.sv
module bba_ctrl
  import bba_pkg::*;
#(
  parameter int BLOCK_BYTES = 64
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           dataValid,
  input  logic                           msgStart,
  input  logic                           dataLast,
  input  logic                           engDone,
  output strobe_t                        strobe,
  output logic [$clog2(BLOCK_BYTES)-1:0] laneIdx,
  output logic                           inReady,
  output logic                           done,
  output logic                           engStart,
  output logic                           engFirst
);

  localparam int LANE_W = $clog2(BLOCK_BYTES);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(BLOCK_BYTES - 1);

  state_t            state, stateNext;
  logic [LANE_W-1:0] byteCnt;
  logic              firstBlk;
  logic              lastBlk;
  logic              engStartQ;
  logic              accept;
  logic              blockFull;
  logic              malformed;

  assign inReady   = (state == ST_IDLE) || (state == ST_LOAD);
  // in idle only a flagged first byte opens a message
  assign accept    = inReady && dataValid && ((state == ST_LOAD) || msgStart);
  assign blockFull = accept && (byteCnt == LAST_LANE);
  assign malformed = accept && dataLast && !blockFull;

  assign laneIdx  = byteCnt;
  assign done     = (state == ST_DONE);
  assign engStart = engStartQ;
  assign engFirst = firstBlk;

  always_comb begin
    strobe.loadByte    = accept && !malformed;
    strobe.clearBlock  = malformed;
    strobe.captureHash = (state == ST_HASH) && engDone;
  end

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE, ST_LOAD: begin
        if (blockFull)      stateNext = ST_HASH;
        else if (malformed) stateNext = ST_IDLE;
        else if (accept)    stateNext = ST_LOAD;
      end
      ST_HASH: begin
        if (engDone) stateNext = lastBlk ? ST_DONE : ST_LOAD;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      byteCnt   <= '0;
      firstBlk  <= 1'b0;
      lastBlk   <= 1'b0;
      engStartQ <= 1'b0;
    end else begin
      state     <= stateNext;
      engStartQ <= blockFull;
      if (accept) begin
        if (blockFull || malformed) byteCnt <= '0;
        else                        byteCnt <= byteCnt + 1'b1;
      end
      if (accept && (state == ST_IDLE)) firstBlk <= 1'b1;
      else if (strobe.captureHash)      firstBlk <= 1'b0;
      if (blockFull) lastBlk <= dataLast;
    end
  end

  // R4: launch strobe lasts one cycle
  a_r4_start_pulse: assert property (@(posedge clk) disable iff (rst)
    engStart |=> !engStart);

  // R5: no byte accepted while a launched block is pending
  a_r5_busy_on_launch: assert property (@(posedge clk) disable iff (rst)
    engStart |-> !inReady);

  // R7: completion indication is a single pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: a discarded block never launches and the controller is ready again
  a_r9_no_launch: assert property (@(posedge clk) disable iff (rst)
    strobe.clearBlock |=> (!engStart && inReady));

endmodule

// File: rtl/bba_datapath.sv
module bba_datapath
  import bba_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int BLOCK_BYTES = 64,
  parameter int DIGEST_W    = 256
) (
  input  logic                           clk,
  input  logic                           rst,
  input  strobe_t                        strobe,
  input  logic [$clog2(BLOCK_BYTES)-1:0] laneIdx,
  input  logic [BYTE_W-1:0]              dataIn,
  input  logic [DIGEST_W-1:0]            engHash,
  output logic [BYTE_W*BLOCK_BYTES-1:0]  blockBuf,
  output logic [DIGEST_W-1:0]            chainHash
);

  localparam int BLOCK_W = BYTE_W * BLOCK_BYTES;
  localparam int LANE_W  = $clog2(BLOCK_BYTES);

  // lane 0 sits at the top of the block, later lanes descend
  for (genvar lane = 0; lane < BLOCK_BYTES; lane++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || strobe.clearBlock)
        blockBuf[BLOCK_W-1-lane*BYTE_W -: BYTE_W] <= '0;
      else if (strobe.loadByte && (laneIdx == LANE_W'(lane)))
        blockBuf[BLOCK_W-1-lane*BYTE_W -: BYTE_W] <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                     chainHash <= '0;
    else if (strobe.captureHash) chainHash <= engHash;
  end

  // R2: an accepted byte appears in its descending lane
  a_r2_lane_write: assert property (@(posedge clk) disable iff (rst)
    strobe.loadByte |=>
      (blockBuf[BLOCK_W-1-int'($past(laneIdx))*BYTE_W -: BYTE_W] == $past(dataIn)));

  // R8: result register moves only on a completion
  a_r8_digest_hold: assert property (@(posedge clk) disable iff (rst)
    !strobe.captureHash |=> $stable(chainHash));

  // R9: a malformed message leaves an empty block
  a_r9_block_cleared: assert property (@(posedge clk) disable iff (rst)
    strobe.clearBlock |=> (blockBuf == '0));

endmodule

// File: rtl/byte_block_assembler.sv
module byte_block_assembler
  import bba_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int BLOCK_BYTES = 64,
  parameter int DIGEST_W    = 256
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [BYTE_W-1:0]             dataIn,
  input  logic                          dataValid,
  input  logic                          msgStart,
  input  logic                          dataLast,
  output logic                          inReady,
  output logic                          done,
  output logic [DIGEST_W-1:0]           digest,
  output logic                          engStart,
  output logic                          engFirst,
  output logic [BYTE_W*BLOCK_BYTES-1:0] engBlock,
  output logic [DIGEST_W-1:0]           engChain,
  input  logic                          engDone,
  input  logic [DIGEST_W-1:0]           engHash
);

  localparam int LANE_W = $clog2(BLOCK_BYTES);

  strobe_t           strobe;
  logic [LANE_W-1:0] laneIdx;
  logic [DIGEST_W-1:0] chainHash;

  bba_ctrl #(
    .BLOCK_BYTES(BLOCK_BYTES)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .dataValid(dataValid),
    .msgStart (msgStart),
    .dataLast (dataLast),
    .engDone  (engDone),
    .strobe   (strobe),
    .laneIdx  (laneIdx),
    .inReady  (inReady),
    .done     (done),
    .engStart (engStart),
    .engFirst (engFirst)
  );

  bba_datapath #(
    .BYTE_W     (BYTE_W),
    .BLOCK_BYTES(BLOCK_BYTES),
    .DIGEST_W   (DIGEST_W)
  ) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .laneIdx  (laneIdx),
    .dataIn   (dataIn),
    .engHash  (engHash),
    .blockBuf (engBlock),
    .chainHash(chainHash)
  );

  assign digest   = chainHash;
  assign engChain = chainHash;

endmodule

// File: tb/byte_block_assembler_tb.sv
module byte_block_assembler_tb;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst;
  logic [7:0]   dataIn;
  logic         dataValid, msgStart, dataLast;
  logic         inReady, done, engStart, engFirst, engDone;
  logic [255:0] digest, engChain, engHash;
  logic [511:0] engBlock;

  int checks = 0;
  int errors = 0;
  logic [255:0] lastDigest = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_block_assembler u_dut (
    .clk(clk), .rst(rst), .dataIn(dataIn), .dataValid(dataValid),
    .msgStart(msgStart), .dataLast(dataLast), .inReady(inReady), .done(done),
    .digest(digest), .engStart(engStart), .engFirst(engFirst),
    .engBlock(engBlock), .engChain(engChain), .engDone(engDone), .engHash(engHash)
  );

  // vectors: blocks in message, seed, engine latency, input gaps
  localparam int VEC [4][4] = '{
    '{1,  3, 1, 0},
    '{2, 17, 3, 1},
    '{3, 40, 5, 0},
    '{1, 99, 2, 1}
  };

  function automatic logic [7:0] byteVal(int seed, int idx);
    return 8'(seed * 29 + idx * 7 + (idx >> 6));
  endfunction

  function automatic logic [511:0] expBlock(int seed, int blk);
    logic [511:0] v = '0;
    for (int i = 0; i < 64; i++) v[511-8*i -: 8] = byteVal(seed, blk*64 + i);
    return v;
  endfunction

  function automatic logic [255:0] hashVal(int seed, int blk);
    return {8{32'(seed * 32'h0100_0193 + blk * 32'h9e37 + 1)}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendMessage(input int nBlk, input int seed, input int lat, input int gap);
    logic [255:0] prevHash = '0;
    for (int b = 0; b < nBlk; b++) begin
      for (int i = 0; i < 64; i++) begin
        while (!inReady) @(negedge clk);
        dataIn    = byteVal(seed, b*64 + i);
        dataValid = 1'b1;
        msgStart  = (b == 0) && (i == 0);
        dataLast  = (b == nBlk-1) && (i == 63);
        @(negedge clk);
        dataValid = 1'b0; msgStart = 1'b0; dataLast = 1'b0;
        if (gap != 0 && i != 63 && (i % 5) == 0) @(negedge clk);
      end
      // launch cycle
      chk(engStart == 1'b1, "R4 launch", engStart, 1);
      chk(inReady == 1'b0, "R5 busy at launch", inReady, 0);
      chk(engBlock == expBlock(seed, b), "R2 block layout", engBlock, expBlock(seed, b));
      chk(engFirst == (b == 0), "R4/R6 first flag", engFirst, (b == 0));
      if (b > 0) chk(engChain == prevHash, "R6 chain value", engChain, prevHash);
      else       chk(digest == lastDigest, "R8 digest held while loading", digest, lastDigest);
      // R10: push a byte while busy
      dataIn = 8'hee; dataValid = 1'b1; msgStart = 1'b1;
      @(negedge clk);
      dataValid = 1'b0; msgStart = 1'b0;
      chk(engStart == 1'b0, "R4 launch is one cycle", engStart, 0);
      repeat (lat) @(negedge clk);
      chk(inReady == 1'b0, "R5 busy until completion", inReady, 0);
      chk(engBlock == expBlock(seed, b), "R10 block untouched while busy", engBlock, expBlock(seed, b));
      engDone = 1'b1; engHash = hashVal(seed, b);
      @(negedge clk);
      engDone = 1'b0; engHash = '0;
      prevHash = hashVal(seed, b);
      if (b == nBlk-1) begin
        chk(done == 1'b1, "R7 done pulse", done, 1);
        chk(digest == prevHash, "R7 digest value", digest, prevHash);
        @(negedge clk);
        chk(done == 1'b0, "R7 done single cycle", done, 0);
        chk(digest == prevHash, "R8 digest stable", digest, prevHash);
        lastDigest = prevHash;
      end else begin
        chk(inReady == 1'b1, "R5 ready after completion", inReady, 1);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; dataIn = '0; dataValid = 1'b0; msgStart = 1'b0; dataLast = 1'b0;
    engDone = 1'b0; engHash = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(inReady == 1'b1, "R1 inReady", inReady, 1);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(engStart == 1'b0, "R1 engStart", engStart, 0);
    chk(digest == '0, "R1 digest", digest, 0);
    chk(engBlock == '0, "R1 engBlock", engBlock, 0);

    // R3: byte without start flag while idle
    dataIn = 8'h5a; dataValid = 1'b1;
    @(negedge clk);
    dataValid = 1'b0;
    @(negedge clk);
    chk(engBlock == '0, "R3 stray byte ignored", engBlock, 0);
    chk(inReady == 1'b1, "R3 still idle", inReady, 1);

    for (int v = 0; v < 4; v++) sendMessage(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);

    // R9: last flag on the tenth byte of a block
    while (!inReady) @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      dataIn = byteVal(7, i); dataValid = 1'b1;
      msgStart = (i == 0); dataLast = (i == 9);
      @(negedge clk);
      dataValid = 1'b0; msgStart = 1'b0; dataLast = 1'b0;
      if (i == 8)
        chk(engBlock[511:504] == byteVal(7, 0), "R2 partial block top byte",
            engBlock[511:504], byteVal(7, 0));
    end
    chk(engBlock == '0, "R9 block discarded", engBlock, 0);
    chk(inReady == 1'b1, "R9 ready again", inReady, 1);
    chk(engStart == 1'b0, "R9 no launch", engStart, 0);
    repeat (3) @(negedge clk);
    chk(engStart == 1'b0 && done == 1'b0, "R9 no launch later", {engStart, done}, 0);
    chk(digest == lastDigest, "R8 digest kept after malformed", digest, lastDigest);

    // R9: a fresh message still works after the discard
    sendMessage(2, 55, 4, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule